// File: doc/BRIEF.md
# Phased Event-Triggered Capture Controller

This block steers the writing of a multi-channel sample stream into a circular store. It produces a write strobe and a wrapping write address for each sample the acquisition path marks as valid. The store keeps filling until a trigger is accepted. After that, a programmed number of further samples is written and capture stops with a completion flag.

Capture moves through ordered phases. An arm event starts the pre-trigger phase. Once the programmed pre-trigger sample count has been written, the controller waits for the trigger event. The trigger moves it to the post-trigger phase, and the address of the first post-trigger sample is latched for the host. The arm event and the trigger event are configured separately. Each one comes from either a software strobe or a chosen edge of a filtered digital line, so capture can be gated between two edges as well as started by a single edge. An optional decimating tap marks every Nth written sample for a live monitor path.

Top module: `phased_capture`

## Requirements
- R1: After reset, phase_o is 0 (idle), and wr_en_o, done_o, mon_valid_o and trig_addr_o are all zero.
- R2: Phase codes are 0 idle, 1 pre-trigger, 2 waiting for trigger, 3 post-trigger, 4 done. An arm event in idle moves to phase 1, and the first write after it goes to address 0.
- R3: In phases 1 and 2, wr_en_o follows sample_valid_i. Every write advances wr_addr_o by one, modulo 2^ADDR_W. No write occurs in phases 0 or 4.
- R4: Phase 2 is entered only after at least pre_len_i writes in phase 1, where pre_len_i may equal the full depth. A trigger event seen in phase 1 is ignored.
- R5: A trigger event in phase 2 moves to phase 3. trig_addr_o then holds the address of the first post-trigger write and does not change until the next trigger.
- R6: Exactly post_len_i writes occur in phase 3, which may be zero. The controller then enters phase 4 with done_o high, and no further writes occur.
- R7: A source select of 0 takes the filtered digital line and 1 takes sw_evt_i. An edge select of 0 picks the rising edge and 1 picks the falling edge. Arm and trigger have separate selects and may name the same event.
- R8: A level on dig_evt_i counts only after it has been stable for MIN_PULSE cycles behind a two-flop synchroniser. Shorter pulses produce no event.
- R9: abort_i returns the controller to phase 0 on the next cycle from any phase and clears done_o.
- R10: mon_valid_o pulses only together with wr_en_o. It marks the 1st, (N+1)th, (2N+1)th… write since arming, where N = decim_i and N of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| abort_i | input | 1 | Synchronous abort to idle |
| sample_valid_i | input | 1 | One sample available this cycle |
| dig_evt_i | input | 1 | Asynchronous digital event line |
| sw_evt_i | input | 1 | Software event strobe, one cycle |
| arm_src_i | input | 1 | Arm source: 0 digital, 1 software |
| arm_edge_i | input | 1 | Arm edge: 0 rising, 1 falling |
| trig_src_i | input | 1 | Trigger source: 0 digital, 1 software |
| trig_edge_i | input | 1 | Trigger edge: 0 rising, 1 falling |
| pre_len_i | input | ADDR_W+1 | Minimum pre-trigger sample count |
| post_len_i | input | ADDR_W+1 | Post-trigger sample count |
| decim_i | input | DECIM_W | Monitor decimation factor |
| wr_en_o | output | 1 | Store write strobe |
| wr_addr_o | output | ADDR_W | Store write address |
| trig_addr_o | output | ADDR_W | Address of first post-trigger sample |
| phase_o | output | 3 | Current phase code |
| done_o | output | 1 | Capture complete |
| mon_valid_o | output | 1 | Written sample selected for monitor |

## Verification
The bench builds the block with ADDR_W of 4, which gives a 16-entry store, so runs with pre- and post-trigger lengths of a full depth wrap the address and exercise both length limits within a few dozen samples. MIN_PULSE stays at 10. With that value, a 5-cycle glitch on the digital line falls below the filter while held levels of 14 cycles or more pass it. DECIM_W of 4 allows factors of 0, 1 and 3, which cover the treat-as-one rule and a true decimation pattern checked against the write count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PRE  = 3'd1,
    PH_WAIT = 3'd2,
    PH_POST = 3'd3,
    PH_DONE = 3'd4
  } phase_e;
endpackage

// File: rtl/evt_filter.sv
module evt_filter #(
  parameter int MIN_PULSE = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic s1, s2, filt, filt_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b0; s2 <= 1'b0; filt <= 1'b0; filt_q <= 1'b0; cnt <= '0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      filt_q <= filt;
      if (s2 == filt) cnt <= '0;
      else if (cnt == CW'(MIN_PULSE - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end

  assign rise_o = filt & ~filt_q;
  assign fall_o = ~filt & filt_q;
endmodule

// File: rtl/evt_pick.sv
module evt_pick (
  input  logic src_i,
  input  logic edge_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic sw_i,
  output logic fire_o
);
  always_comb begin
    if (src_i) fire_o = sw_i;
    else       fire_o = edge_i ? fall_i : rise_i;
  end
endmodule

// File: rtl/cap_fsm.sv
module cap_fsm
  import cap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              valid_i,
  input  logic              arm_fire_i,
  input  logic              trig_fire_i,
  input  logic [ADDR_W:0]   pre_len_i,
  input  logic [ADDR_W:0]   post_len_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [ADDR_W-1:0] trig_addr_o,
  output phase_e            phase_o,
  output logic              done_o
);
  phase_e            phase;
  logic [ADDR_W:0]   cnt;
  logic [ADDR_W-1:0] addr;

  always_comb begin
    unique case (phase)
      PH_PRE, PH_WAIT: wr_en_o = valid_i;
      PH_POST:         wr_en_o = valid_i && (cnt < post_len_i);
      default:         wr_en_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr <= '0;
    else if (phase == PH_IDLE && arm_fire_i) addr <= '0;
    else if (wr_en_o) addr <= addr + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase       <= PH_IDLE;
      cnt         <= '0;
      trig_addr_o <= '0;
    end else if (abort_i) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: if (arm_fire_i) begin
          phase <= PH_PRE;
          cnt   <= '0;
        end
        PH_PRE: begin
          if (cnt >= pre_len_i) phase <= PH_WAIT;
          else if (wr_en_o)     cnt   <= cnt + 1'b1;
        end
        PH_WAIT: if (trig_fire_i) begin
          phase       <= PH_POST;
          cnt         <= '0;
          // a write in this cycle still belongs to the pre-trigger data
          trig_addr_o <= addr + {{(ADDR_W-1){1'b0}}, wr_en_o};
        end
        PH_POST: begin
          if (cnt >= post_len_i) phase <= PH_DONE;
          else if (wr_en_o)      cnt   <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign wr_addr_o = addr;
  assign phase_o   = phase;
  assign done_o    = (phase == PH_DONE);
endmodule

// File: rtl/sub_tap.sv
module sub_tap #(
  parameter int DECIM_W = 8,
  parameter bit EN      = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_en_i,
  input  logic [DECIM_W-1:0] decim_i,
  output logic               mon_o
);
  generate
    if (EN) begin : g_tap
      logic [DECIM_W-1:0] dcnt;
      logic [DECIM_W:0]   nxt;
      assign nxt   = {1'b0, dcnt} + 1'b1;
      assign mon_o = wr_en_i && (dcnt == '0);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      dcnt <= '0;
        else if (clr_i)   dcnt <= '0;
        else if (wr_en_i) dcnt <= (nxt >= {1'b0, decim_i}) ? '0 : nxt[DECIM_W-1:0];
      end
    end else begin : g_off
      assign mon_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/phased_capture.sv
module phased_capture
  import cap_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int MIN_PULSE = 10,
  parameter int DECIM_W   = 8,
  parameter bit SUB_EN    = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               sample_valid_i,
  input  logic               dig_evt_i,
  input  logic               sw_evt_i,
  input  logic               arm_src_i,
  input  logic               arm_edge_i,
  input  logic               trig_src_i,
  input  logic               trig_edge_i,
  input  logic [ADDR_W:0]    pre_len_i,
  input  logic [ADDR_W:0]    post_len_i,
  input  logic [DECIM_W-1:0] decim_i,
  output logic               wr_en_o,
  output logic [ADDR_W-1:0]  wr_addr_o,
  output logic [ADDR_W-1:0]  trig_addr_o,
  output logic [2:0]         phase_o,
  output logic               done_o,
  output logic               mon_valid_o
);
  logic   d_rise, d_fall, arm_fire, trig_fire;
  phase_e phase;

  evt_filter #(.MIN_PULSE(MIN_PULSE)) u_filt (
    .clk_i, .rst_ni, .line_i(dig_evt_i), .rise_o(d_rise), .fall_o(d_fall)
  );

  evt_pick u_arm (
    .src_i(arm_src_i), .edge_i(arm_edge_i), .rise_i(d_rise), .fall_i(d_fall),
    .sw_i(sw_evt_i), .fire_o(arm_fire)
  );

  evt_pick u_trig (
    .src_i(trig_src_i), .edge_i(trig_edge_i), .rise_i(d_rise), .fall_i(d_fall),
    .sw_i(sw_evt_i), .fire_o(trig_fire)
  );

  cap_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni, .abort_i, .valid_i(sample_valid_i),
    .arm_fire_i(arm_fire), .trig_fire_i(trig_fire),
    .pre_len_i, .post_len_i, .wr_en_o, .wr_addr_o, .trig_addr_o,
    .phase_o(phase), .done_o
  );

  sub_tap #(.DECIM_W(DECIM_W), .EN(SUB_EN)) u_tap (
    .clk_i, .rst_ni, .clr_i(phase == PH_IDLE), .wr_en_i(wr_en_o),
    .decim_i, .mon_o(mon_valid_o)
  );

  assign phase_o = phase;
endmodule

// File: rtl/phased_capture_chk.sv
module phased_capture_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              abort_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] trig_addr_o,
  input logic [2:0]        phase_o,
  input logic              done_o,
  input logic              mon_valid_o
);
  p_no_idle_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 || phase_o == 3'd4) |-> !wr_en_o);

  p_addr_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1));

  p_pre_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |=> (phase_o <= 3'd2));

  p_trig_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3) |=> $stable(trig_addr_o));

  p_done_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(phase_o) == 3'd3);

  p_abort_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (phase_o == 3'd0 && !done_o));

  p_mon_in_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mon_valid_o |-> wr_en_o);
endmodule

bind phased_capture phased_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .abort_i, .wr_en_o, .wr_addr_o, .trig_addr_o,
  .phase_o, .done_o, .mon_valid_o
);

// File: tb/sim_phased_capture.sv
module sim_phased_capture;
  localparam int AW = 4;
  localparam int DW = 4;

  logic clk = 1'b0, rst_n = 1'b0, abort = 1'b0, valid = 1'b0;
  logic dig = 1'b0, sw = 1'b0;
  logic arm_src = 1'b1, arm_edge = 1'b0, trig_src = 1'b1, trig_edge = 1'b0;
  logic [AW:0] pre_len = '0, post_len = '0;
  logic [DW-1:0] decim = '0;
  logic wr_en, done, mon;
  logic [AW-1:0] wr_addr, trig_addr;
  logic [2:0] phase;

  int n_chk = 0, n_err = 0;
  int n_wr, n_pre, n_post, n_mon;
  logic [AW-1:0] exp_addr, first_post;
  logic [2:0] prev_phase = 3'd0;
  bit pat_run = 1'b0;

  always #2 clk = ~clk;

  phased_capture #(.ADDR_W(AW), .MIN_PULSE(10), .DECIM_W(DW), .SUB_EN(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .abort_i(abort), .sample_valid_i(valid),
    .dig_evt_i(dig), .sw_evt_i(sw), .arm_src_i(arm_src), .arm_edge_i(arm_edge),
    .trig_src_i(trig_src), .trig_edge_i(trig_edge), .pre_len_i(pre_len),
    .post_len_i(post_len), .decim_i(decim), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .trig_addr_o(trig_addr), .phase_o(phase), .done_o(done), .mon_valid_o(mon)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // write monitor: statistics restart when phase 1 is entered
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase == 3'd1 && prev_phase != 3'd1) begin
        n_wr = 0; n_pre = 0; n_post = 0; n_mon = 0; exp_addr = '0;
      end
      if ((phase == 3'd0 || phase == 3'd4) && wr_en)
        chk(1'b0, "R3 write outside capture", 1, 0);
      if (wr_en) begin
        chk(wr_addr == exp_addr, "R3 address sequence", wr_addr, exp_addr);
        exp_addr = exp_addr + 1'b1;
        n_wr++;
        if (phase == 3'd1) n_pre++;
        if (phase == 3'd3) begin
          if (n_post == 0) first_post = wr_addr;
          n_post++;
        end
        if (mon) n_mon++;
      end
      prev_phase = phase;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sw_pulse();
    @(posedge clk); #1 sw = 1'b1;
    @(posedge clk); #1 sw = 1'b0;
  endtask

  task automatic wait_phase(input logic [2:0] p, input int lim, input string req);
    int k = 0;
    while (phase != p && k < lim) begin @(negedge clk); k++; end
    chk(phase == p, req, phase, p);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(3);
    @(negedge clk);
    chk(phase == 3'd0 && !wr_en && !done && !mon && trig_addr == '0, "R1 reset state",
        {phase, wr_en, done, mon}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    cyc(2);
  endtask

  // software arm and trigger on the same event, continuous samples
  task automatic t_sw_same();
    arm_src = 1'b1; trig_src = 1'b1; pre_len = 6; post_len = 5; decim = 1; valid = 1'b1;
    sw_pulse();
    @(negedge clk);
    chk(phase == 3'd1, "R2 R7 software arm enters pre phase", phase, 1);
    sw_pulse();
    @(negedge clk);
    chk(phase == 3'd1, "R4 trigger ignored in pre phase", phase, 1);
    wait_phase(3'd2, 40, "R4 reach trigger wait");
    chk(n_pre >= 6 && n_pre <= 7, "R4 pre count honoured", n_pre, 6);
    sw_pulse();
    wait_phase(3'd4, 60, "R6 reach done");
    chk(n_post == 5, "R6 post count exact", n_post, 5);
    chk(trig_addr == first_post, "R5 trigger address", trig_addr, first_post);
    chk(n_mon == n_wr, "R10 factor one passes all", n_mon, n_wr);
    cyc(6);
    @(negedge clk);
    chk(done && n_post == 5, "R6 done holds, no extra writes", n_post, 5);
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !done, "R9 abort from done clears flag", {phase, done}, 0);
    valid = 1'b0;
  endtask

  // digital gating: rising edge arms, falling edge triggers, sparse samples
  task automatic t_gated_dig();
    arm_src = 1'b0; arm_edge = 1'b0; trig_src = 1'b0; trig_edge = 1'b1;
    pre_len = 16; post_len = 16; decim = 3; valid = 1'b0;
    pat_run = 1'b1;
    fork
      while (pat_run) begin @(posedge clk); #1 valid = ~valid; end
    join_none
    dig = 1'b1; cyc(5); dig = 1'b0; cyc(20);
    @(negedge clk);
    chk(phase == 3'd0, "R8 short pulse rejected", phase, 0);
    @(posedge clk); #1 dig = 1'b1;
    cyc(20);
    @(negedge clk);
    chk(phase == 3'd1, "R7 R8 rising edge arms", phase, 1);
    @(posedge clk); #1 dig = 1'b0;
    cyc(14);
    @(negedge clk);
    chk(phase == 3'd1, "R4 early falling edge ignored", phase, 1);
    @(posedge clk); #1 dig = 1'b1;
    cyc(40);
    @(negedge clk);
    chk(phase == 3'd2, "R4 full-depth pre count then wait", phase, 2);
    chk(n_pre >= 16, "R4 pre writes", n_pre, 16);
    @(posedge clk); #1 dig = 1'b0;
    wait_phase(3'd4, 200, "R6 R7 falling edge triggers and completes");
    chk(n_post == 16, "R6 full-depth post count", n_post, 16);
    chk(trig_addr == first_post, "R5 trigger address after wrap", trig_addr, first_post);
    chk(n_wr > 16, "R3 address wrapped", n_wr, 17);
    chk(n_mon == (n_wr + 2) / 3, "R10 every third write", n_mon, (n_wr + 2) / 3);
    pat_run = 1'b0;
    cyc(2);
    valid = 1'b0;
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
  endtask

  task automatic t_abort_post();
    arm_src = 1'b1; trig_src = 1'b1; pre_len = 2; post_len = 10; decim = 1; valid = 1'b1;
    sw_pulse();
    wait_phase(3'd2, 20, "R2 arm for abort test");
    sw_pulse();
    wait_phase(3'd3, 5, "R5 enter post phase");
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    @(negedge clk);
    chk(phase == 3'd0 && !done && !wr_en, "R9 abort in post phase", phase, 0);
    valid = 1'b0;
  endtask

  task automatic t_zero_len();
    arm_src = 1'b1; trig_src = 1'b1; pre_len = 0; post_len = 0; decim = 0; valid = 1'b1;
    sw_pulse();
    wait_phase(3'd2, 10, "R4 zero pre length");
    sw_pulse();
    wait_phase(3'd4, 10, "R6 zero post length");
    chk(n_post == 0, "R6 no post writes", n_post, 0);
    chk(n_mon == n_wr, "R10 factor zero acts as one", n_mon, n_wr);
    valid = 1'b0;
    @(posedge clk); #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_sw_same();
    t_gated_dig();
    t_abort_post();
    t_zero_len();
    cyc(4);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule